// File: doc/BRIEF.md
# High-Speed IO Bank Thaw Sequencer

This block steps the control lines of a high-speed IO bank, the bank that carries memory-interface logic, through an ordered freeze and an ordered thaw. It drives ten controls. Five of them are the usual pad controls: slew enable, weak pull-up, tristate and bus-hold, all active low, plus an active-high configuration-done flag. The other five are specific to this bank: an active-low driver freeze, a regulator freeze, an on-chip-termination reset, a DLL reinit and a termination calibration/bias enable. A one-cycle request starts each sequence. The block reports whether the bank is frozen and whether a sequence is in progress.

The short gaps between steps are counted in system clock cycles. They are derived from the clock frequency parameter: 20 ns while freezing and 40 ns while thawing. The two long waits in the thaw come after calibration is enabled and after termination reset is released. They are counted in cycles of a separate slow internal oscillator. The raw oscillator level is synchronized into the system clock domain, and each rising edge becomes a one-cycle tick. The default counts are 1000 and 33 ticks. At the oscillator's fastest rate of 50 MHz these are about 20 us and 660 ns.

Top module: `hsio_thaw_seq`

## Requirements
- R1: After reset the bank is frozen. `frozen`=1, `busy`=0, slew_n, wkpu_n, tri_n, bhold_n, cfg_done and drv_frz_n are 0, reg_frz, oct_rst and dll_reinit are 1, and cal_en is 0.
- R2: The freeze runs in three steps. First slew_n, wkpu_n and tri_n go low. No fewer than ceil(20 ns × CLK_MHZ) cycles later, bhold_n, cfg_done and drv_frz_n go low while reg_frz and oct_rst go high. Finally dll_reinit goes high and cal_en goes low.
- R3: The thaw first drops dll_reinit. cal_en rises no fewer than ceil(40 ns × CLK_MHZ) cycles after that.
- R4: After cal_en rises, the block waits LONG_TICKS oscillator ticks. It then raises bhold_n, cfg_done and drv_frz_n and drops oct_rst, all in the same cycle.
- R5: After the R4 step, the block waits SHORT_TICKS oscillator ticks. It then raises wkpu_n and tri_n together.
- R6: At least the 40 ns gap after the R5 step, reg_frz falls. At least the 40 ns gap after that, slew_n rises, and the thaw is complete.
- R7: `busy` is high from the cycle after an accepted request until the last step. `frozen` changes only in the cycle in which busy falls: it becomes 1 at the end of a freeze and 0 at the end of a thaw.
- R8: A freeze request is ignored while the bank is frozen. A thaw request is ignored while it is thawed. Either request is ignored while busy. An ignored request changes no output.
- R9: Each rising edge of `osc_in` becomes exactly one tick. A tick lasts one system clock cycle and advances an oscillator wait by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freeze_req | input | 1 | One-cycle request to freeze the bank |
| thaw_req | input | 1 | One-cycle request to thaw the bank |
| osc_in | input | 1 | Raw level of the slow internal oscillator |
| slew_n | output | 1 | Slew control enable, active low |
| wkpu_n | output | 1 | Weak pull-up control, active low |
| tri_n | output | 1 | Tristate control, active low |
| bhold_n | output | 1 | Bus-hold control, active low |
| cfg_done | output | 1 | Configuration done, active high |
| drv_frz_n | output | 1 | Driver freeze, active low |
| reg_frz | output | 1 | Regulator freeze, active high |
| oct_rst | output | 1 | On-chip termination reset, active high |
| dll_reinit | output | 1 | DLL reinit, active high |
| cal_en | output | 1 | Termination calibration / bias enable |
| frozen | output | 1 | Bank is frozen |
| busy | output | 1 | A sequence is running |

## Verification
A sequencer that skips or reorders a state shows up at the ports as soon as it happens. Either a control changes to a value other than the next one in the step list, or two steps come closer together than their minimum gap. Both are visible at the first output change after the fault. A wait counter that is loaded wrongly, or a tick synchronizer that produces double or missing pulses, stretches or shortens the gap before the next step. The bench measures each gap in system cycles and in raw oscillator edges. A wrong frozen or busy flag is exposed at the end of each sequence and by requests that should have been ignored.

// File: rtl/hsio_pkg.sv
package hsio_pkg;

  typedef struct packed {
    logic slew_n;
    logic wkpu_n;
    logic tri_n;
    logic bhold_n;
    logic cfg_done;
    logic drv_frz_n;
    logic reg_frz;
    logic oct_rst;
    logic dll_reinit;
    logic cal_en;
  } ctrl_t;

  localparam ctrl_t CTRL_FROZEN = '{
    slew_n: 1'b0, wkpu_n: 1'b0, tri_n: 1'b0, bhold_n: 1'b0,
    cfg_done: 1'b0, drv_frz_n: 1'b0, reg_frz: 1'b1, oct_rst: 1'b1,
    dll_reinit: 1'b1, cal_en: 1'b0
  };

  typedef enum logic [4:0] {
    ST_FROZEN,
    ST_THAWED,
    ST_F_IO,
    ST_F_W1,
    ST_F_HOLD,
    ST_F_W2,
    ST_F_DLL,
    ST_T_DLL,
    ST_T_W1,
    ST_T_CAL,
    ST_T_W2,
    ST_T_HOLD,
    ST_T_W3,
    ST_T_IO,
    ST_T_W4,
    ST_T_REG,
    ST_T_W5,
    ST_T_SLEW
  } seq_st_e;

endpackage

// File: rtl/hsio_tick_sync.sv
module hsio_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], osc_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~last_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9

endmodule

// File: rtl/hsio_wait_ctr.sv
module hsio_wait_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          use_tick,
  input  logic          tick,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          step;

  assign step = mode_q ? tick : 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (load) begin
      cnt_d  = len;
      mode_d = use_tick;
    end else if (step && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign done = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0); // R4
  AST_TICK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mode_q && !tick) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/hsio_seq_fsm.sv
module hsio_seq_fsm
  import hsio_pkg::*;
#(
  parameter int CW          = 10,
  parameter int GAP_FRZ     = 3,
  parameter int GAP_THAW    = 5,
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_req,
  input  logic          thaw_req,
  input  logic          wt_done,
  output logic          wt_load,
  output logic [CW-1:0] wt_len,
  output logic          wt_tick,
  output ctrl_t         ctrl,
  output logic          frozen,
  output logic          busy
);

  seq_st_e st_q, st_d;
  ctrl_t   ctrl_q, ctrl_d;
  logic    frz_q, frz_d;

  always_comb begin
    st_d    = st_q;
    ctrl_d  = ctrl_q;
    frz_d   = frz_q;
    wt_load = 1'b0;
    wt_len  = '0;
    wt_tick = 1'b0;
    unique case (st_q)
      ST_FROZEN: if (thaw_req)   st_d = ST_T_DLL;
      ST_THAWED: if (freeze_req) st_d = ST_F_IO;
      ST_F_IO: begin
        ctrl_d.slew_n = 1'b0;
        ctrl_d.wkpu_n = 1'b0;
        ctrl_d.tri_n  = 1'b0;
        wt_load = 1'b1;
        wt_len  = CW'(GAP_FRZ);
        st_d    = ST_F_W1;
      end
      ST_F_W1: if (wt_done) st_d = ST_F_HOLD;
      ST_F_HOLD: begin
        ctrl_d.bhold_n   = 1'b0;
        ctrl_d.cfg_done  = 1'b0;
        ctrl_d.drv_frz_n = 1'b0;
        ctrl_d.reg_frz   = 1'b1;
        ctrl_d.oct_rst   = 1'b1;
        wt_load = 1'b1;
        wt_len  = CW'(GAP_FRZ);
        st_d    = ST_F_W2;
      end
      ST_F_W2: if (wt_done) st_d = ST_F_DLL;
      ST_F_DLL: begin
        ctrl_d.dll_reinit = 1'b1;
        ctrl_d.cal_en     = 1'b0;
        frz_d = 1'b1;
        st_d  = ST_FROZEN;
      end
      ST_T_DLL: begin
        ctrl_d.dll_reinit = 1'b0;
        wt_load = 1'b1;
        wt_len  = CW'(GAP_THAW);
        st_d    = ST_T_W1;
      end
      ST_T_W1: if (wt_done) st_d = ST_T_CAL;
      ST_T_CAL: begin
        ctrl_d.cal_en = 1'b1;
        wt_load = 1'b1;
        wt_len  = CW'(LONG_TICKS);
        wt_tick = 1'b1;
        st_d    = ST_T_W2;
      end
      ST_T_W2: if (wt_done) st_d = ST_T_HOLD;
      ST_T_HOLD: begin
        ctrl_d.bhold_n   = 1'b1;
        ctrl_d.cfg_done  = 1'b1;
        ctrl_d.drv_frz_n = 1'b1;
        ctrl_d.oct_rst   = 1'b0;
        wt_load = 1'b1;
        wt_len  = CW'(SHORT_TICKS);
        wt_tick = 1'b1;
        st_d    = ST_T_W3;
      end
      ST_T_W3: if (wt_done) st_d = ST_T_IO;
      ST_T_IO: begin
        ctrl_d.wkpu_n = 1'b1;
        ctrl_d.tri_n  = 1'b1;
        wt_load = 1'b1;
        wt_len  = CW'(GAP_THAW);
        st_d    = ST_T_W4;
      end
      ST_T_W4: if (wt_done) st_d = ST_T_REG;
      ST_T_REG: begin
        ctrl_d.reg_frz = 1'b0;
        wt_load = 1'b1;
        wt_len  = CW'(GAP_THAW);
        st_d    = ST_T_W5;
      end
      ST_T_W5: if (wt_done) st_d = ST_T_SLEW;
      ST_T_SLEW: begin
        ctrl_d.slew_n = 1'b1;
        frz_d = 1'b0;
        st_d  = ST_THAWED;
      end
      default: st_d = ST_FROZEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FROZEN;
      ctrl_q <= CTRL_FROZEN;
      frz_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
      frz_q  <= frz_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign frozen = frz_q;
  assign busy   = (st_q != ST_FROZEN) && (st_q != ST_THAWED);

  AST_IDLE_FROZEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frozen) |-> ctrl_q == CTRL_FROZEN); // R1
  AST_HOLD_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.bhold_n) |-> (!ctrl_q.slew_n && !ctrl_q.wkpu_n && !ctrl_q.tri_n)); // R2
  AST_CAL_AFTER_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.cal_en) |-> !ctrl_q.dll_reinit); // R3
  AST_OCT_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.oct_rst) |-> ctrl_q.cal_en); // R4
  AST_TRI_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.tri_n) |-> (ctrl_q.cfg_done && !ctrl_q.oct_rst)); // R5
  AST_SLEW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.slew_n) |-> (!ctrl_q.reg_frz && ctrl_q.tri_n)); // R6
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(frz_q) |-> $fell(busy)); // R7
  AST_IGNORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FROZEN && !thaw_req) |=> st_q == ST_FROZEN); // R8

endmodule

// File: rtl/hsio_thaw_seq.sv
module hsio_thaw_seq
  import hsio_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_req,
  input  logic thaw_req,
  input  logic osc_in,
  output logic slew_n,
  output logic wkpu_n,
  output logic tri_n,
  output logic bhold_n,
  output logic cfg_done,
  output logic drv_frz_n,
  output logic reg_frz,
  output logic oct_rst,
  output logic dll_reinit,
  output logic cal_en,
  output logic frozen,
  output logic busy
);

  localparam int GAP_FRZ  = (20 * CLK_MHZ + 999) / 1000;
  localparam int GAP_THAW = (40 * CLK_MHZ + 999) / 1000;
  localparam int MAX_A    = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int MAX_B    = (GAP_THAW > GAP_FRZ) ? GAP_THAW : GAP_FRZ;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_LEN + 1);

  logic          tick;
  logic          wt_load, wt_tick, wt_done;
  logic [CW-1:0] wt_len;
  ctrl_t         ctrl;

  hsio_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .tick(tick)
  );

  hsio_wait_ctr #(.CW(CW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wt_load), .len(wt_len),
    .use_tick(wt_tick), .tick(tick), .done(wt_done)
  );

  hsio_seq_fsm #(
    .CW(CW), .GAP_FRZ(GAP_FRZ), .GAP_THAW(GAP_THAW),
    .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .wt_done(wt_done), .wt_load(wt_load), .wt_len(wt_len), .wt_tick(wt_tick),
    .ctrl(ctrl), .frozen(frozen), .busy(busy)
  );

  assign slew_n     = ctrl.slew_n;
  assign wkpu_n     = ctrl.wkpu_n;
  assign tri_n      = ctrl.tri_n;
  assign bhold_n    = ctrl.bhold_n;
  assign cfg_done   = ctrl.cfg_done;
  assign drv_frz_n  = ctrl.drv_frz_n;
  assign reg_frz    = ctrl.reg_frz;
  assign oct_rst    = ctrl.oct_rst;
  assign dll_reinit = ctrl.dll_reinit;
  assign cal_en     = ctrl.cal_en;

endmodule

// File: tb/hsio_thaw_seq_tb.sv
module hsio_thaw_seq_tb;

  localparam int GAP_F = 3;
  localparam int GAP_T = 5;
  localparam int LONG  = 1000;
  localparam int SHORT = 33;
  localparam logic [9:0] V_FROZEN = 10'b0000001110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze_req = 1'b0;
  logic thaw_req = 1'b0;
  logic osc = 1'b0;
  logic slew_n, wkpu_n, tri_n, bhold_n, cfg_done, drv_frz_n;
  logic reg_frz, oct_rst, dll_reinit, cal_en, frozen, busy;
  logic [9:0] vec;

  int checks = 0;
  int errors = 0;

  logic [9:0] qv[$];
  int         qc[$];
  int         qo[$];
  string      qs[$];

  always #4 clk = ~clk;

  always begin
    repeat (4) @(posedge clk);
    #1 osc = ~osc;
  end

  hsio_thaw_seq u_dut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .osc_in(osc), .slew_n(slew_n), .wkpu_n(wkpu_n), .tri_n(tri_n),
    .bhold_n(bhold_n), .cfg_done(cfg_done), .drv_frz_n(drv_frz_n),
    .reg_frz(reg_frz), .oct_rst(oct_rst), .dll_reinit(dll_reinit),
    .cal_en(cal_en), .frozen(frozen), .busy(busy)
  );

  assign vec = {slew_n, wkpu_n, tri_n, bhold_n, cfg_done, drv_frz_n,
                reg_frz, oct_rst, dll_reinit, cal_en};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v, input int mc, input int mo, input string tag);
    qv.push_back(v); qc.push_back(mc); qo.push_back(mo); qs.push_back(tag);
  endtask

  // Monitor: pops the expected output step at each change and checks gaps
  logic [9:0] prev_vec;
  logic       osc_prev;
  int         cyc_since = 0;
  int         osc_since = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_vec  = vec;
      osc_prev  = osc;
      cyc_since = 0;
      osc_since = 0;
    end else begin
      cyc_since++;
      if (osc && !osc_prev) osc_since++;
      osc_prev = osc;
      if (vec !== prev_vec) begin
        if (qv.size() == 0) begin
          check(1'b0, "R8 unexpected output change", int'(vec), int'(prev_vec));
        end else begin
          logic [9:0] ev;
          int mc, mo;
          string tg;
          ev = qv.pop_front(); mc = qc.pop_front();
          mo = qo.pop_front(); tg = qs.pop_front();
          check(vec === ev, {tg, " step value"}, int'(vec), int'(ev));
          check(cyc_since >= mc, {tg, " cycle gap"}, cyc_since, mc);
          check(osc_since >= mo, {tg, " oscillator gap"}, osc_since, mo);
        end
        prev_vec  = vec;
        cyc_since = 0;
        osc_since = 0;
      end
    end
  end

  task automatic pulse(input bit do_thaw);
    @(negedge clk);
    if (do_thaw) thaw_req = 1'b1; else freeze_req = 1'b1;
    @(negedge clk);
    thaw_req = 1'b0; freeze_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_thaw(input bit poke_mid);
    push(10'b0000001100, 0, 0, "R3 dll reinit off");
    push(10'b0000001101, GAP_T, 0, "R3 cal enable");
    push(10'b0001111001, 1, LONG - 2, "R4 hold/cfg/oct release");
    push(10'b0111111001, 1, SHORT - 2, "R5 pull-up/tristate release");
    push(10'b0111110001, GAP_T, 0, "R6 regulator release");
    push(10'b1111110001, GAP_T, 0, "R6 slew release");
    pulse(1'b1);
    @(negedge clk);
    check(busy === 1'b1, "R7 busy during thaw", int'(busy), 1);
    check(frozen === 1'b1, "R7 frozen held while busy", int'(frozen), 1);
    if (poke_mid) begin
      repeat (200) @(negedge clk);
      pulse(1'b0);   // R8: freeze request while busy
      pulse(1'b1);   // R8: thaw request while busy
    end
    wait_idle();
    @(negedge clk);
    check(frozen === 1'b0, "R7 frozen cleared after thaw", int'(frozen), 0);
    check(qv.size() == 0, "R6 all thaw steps seen", qv.size(), 0);
  endtask

  task automatic run_freeze();
    push(10'b0001110001, 0, 0, "R2 slew/pull-up/tristate low");
    push(10'b0000001101, GAP_F, 0, "R2 hold/cfg low, regulator/oct high");
    push(V_FROZEN, 1, 0, "R2 dll reinit on, cal off");
    pulse(1'b0);
    @(negedge clk);
    check(busy === 1'b1, "R7 busy during freeze", int'(busy), 1);
    wait_idle();
    @(negedge clk);
    check(frozen === 1'b1, "R7 frozen set after freeze", int'(frozen), 1);
    check(vec === V_FROZEN, "R2 final frozen controls", int'(vec), int'(V_FROZEN));
    check(qv.size() == 0, "R2 all freeze steps seen", qv.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(vec === V_FROZEN, "R1 reset controls", int'(vec), int'(V_FROZEN));
    check(frozen === 1'b1, "R1 reset frozen", int'(frozen), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);

    pulse(1'b0);   // R8: freeze while frozen
    repeat (30) @(negedge clk);
    check(vec === V_FROZEN, "R8 freeze while frozen ignored", int'(vec), int'(V_FROZEN));
    check(busy === 1'b0, "R8 no busy after ignored freeze", int'(busy), 0);

    run_thaw(1'b1);   // R9: oscillator gaps checked inside

    pulse(1'b1);   // R8: thaw while thawed
    repeat (30) @(negedge clk);
    check(vec === 10'b1111110001, "R8 thaw while thawed ignored", int'(vec), 10'h3F1);
    check(busy === 1'b0, "R8 no busy after ignored thaw", int'(busy), 0);

    run_freeze();
    repeat (10) @(negedge clk);
    run_thaw(1'b0);
    run_freeze();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule